// File: doc/BRIEF.md
# Auto-Ranging Master Clock Prescaler

This block sits between a free-running master clock of unknown (but legal) rate and the sequencing logic of a voice codec. It counts master clock edges between successive rising edges of the 8 kHz transmit frame sync. From that count it picks one of seven supported rates: 256, 512, 1536, 1544, 2048, 2560 or 4096 kHz. Once it is confident of the rate, it issues a one-cycle sequencing strobe 32 times per frame, which is an effective 256 kHz rate. The first strobe of every frame coincides with the frame sync.

The whole block runs in the master clock domain. Frame sync is sampled on the rising clock edge, and only its rising edge matters. The pulse width, whether one cycle (short) or many cycles (long), has no effect. At 193 cycles per frame the divide is not an integer. The strobe is then spaced 6 cycles apart and stops after the 32nd strobe, so the final gap before the next frame is 7 cycles.

Top module: `mclk_autorange`

## Requirements
- R1: While and right after reset, `locked` is 0, `seq_tick` is 0 and `rate_code` is 0.
- R2: A frame's cycle count is the number of rising clock edges from one sampled frame sync rising edge to the next. The first rising edge after reset only starts counting, so at least three frame sync edges are needed before `locked` can rise.
- R3: `rate_code` encodes the locked count as 0=32, 1=64, 2=192, 3=193, 4=256, 5=320, 6=512 cycles per frame.
- R4: When two consecutive frames measure the same exact legal count, `locked` is 1 and `rate_code` holds that count's code. Both are visible after the second clock edge following the edge that samples the closing frame sync. A locked block moves to a new rate on the same rule.
- R5: A count within one cycle of a legal value, but not equal to any legal value, leaves `locked`, `rate_code` and the strobe pattern unchanged. It does break the run of two matching frames.
- R6: A count more than one cycle away from every legal value clears `locked` two edges after the closing frame sync is sampled.
- R7: While locked, `seq_tick` is high in the cycle after the edge that samples a frame sync rising edge. It is then high every D cycles, for 32 strobes in all, where D = count/32 rounded down (1, 2, 6, 6, 8, 10, 16 for codes 0..6). No strobe follows the 32nd until the next frame sync, so at 193 cycles the last gap is 7.
- R8: While `locked` is 0, `seq_tick` stays 0, including for the whole frame in which lock is first gained.
- R9: The width of the frame sync pulse (a single cycle or many cycles) does not change the measured count or the strobe pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, any legal rate |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | 8 kHz transmit frame sync, sampled on clk |
| rate_code | output | 3 | Detected rate code (R3 encoding) |
| locked | output | 1 | Rate detection confident |
| seq_tick | output | 1 | One-cycle 256 kHz sequencing strobe |

## Verification
The bench drives `fsync` on the falling edge and samples every output 1 ns after each rising edge, so strobes are compared against cycle offsets from the sampling edge. Ticks are expected at offsets 0, D, 2D and so on up to 31·D. A change in `locked` or `rate_code` is first expected at offset 1 of the frame that follows the measured frame. Checks that are looking for a new rate skip the one or two frames in which the old rate still drives the strobe. Those frames are only checked where the expected pattern is fully determined, for example the unchanged pattern under a near-miss count.

// File: rtl/mar_pkg.sv
package mar_pkg;
    localparam int NUM_RATES = 7;
    localparam int SEQ_TICKS = 32;

    typedef logic [2:0] rate_code_t;

    function automatic int unsigned rate_cycles(input int unsigned idx);
        case (idx)
            0:       return 32;
            1:       return 64;
            2:       return 192;
            3:       return 193;
            4:       return 256;
            5:       return 320;
            default: return 512;
        endcase
    endfunction

    function automatic int unsigned rate_div(input int unsigned idx);
        return rate_cycles(idx) / SEQ_TICKS;
    endfunction
endpackage

// File: rtl/mar_frame_meter.sv
module mar_frame_meter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic             frame_start,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             fs;
        logic             seen;
        logic [CNT_W-1:0] cnt;
        logic             mv;
        logic [CNT_W-1:0] meas;
    } fm_state_t;

    fm_state_t st_d, st_q;

    assign frame_start = fsync & ~st_q.fs;

    always_comb begin
        st_d    = st_q;
        st_d.fs = fsync;
        st_d.mv = 1'b0;
        if (frame_start) begin
            st_d.cnt  = '0;
            st_d.seen = 1'b1;
            if (st_q.seen) begin
                st_d.mv   = 1'b1;
                st_d.meas = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + 1'b1;
            end
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign meas_valid = st_q.mv;
    assign meas_cnt   = st_q.meas;

    // R2: a measurement only ever follows a sampled frame sync rising edge
    a_r2_meas_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> $past(frame_start));
endmodule

// File: rtl/mar_ratio_lock.sv
module mar_ratio_lock #(
    parameter int CNT_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                meas_valid,
    input  logic [CNT_W-1:0]    meas_cnt,
    output logic                locked,
    output mar_pkg::rate_code_t rate_code
);
    import mar_pkg::*;

    typedef struct packed {
        logic       cand_v;
        rate_code_t cand;
        logic       locked;
        rate_code_t code;
    } rl_state_t;

    rl_state_t  st_d, st_q;
    logic       exact, near;
    rate_code_t hit;

    always_comb begin
        exact = 1'b0;
        near  = 1'b0;
        hit   = '0;
        for (int i = 0; i < NUM_RATES; i++) begin
            int m, l;
            m = int'(meas_cnt);
            l = int'(rate_cycles(i));
            if (m == l) begin
                exact = 1'b1;
                hit   = rate_code_t'(i);
            end
            if ((m + 1 >= l) && (m <= l + 1)) near = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (meas_valid) begin
            if (exact) begin
                st_d.cand_v = 1'b1;
                st_d.cand   = hit;
                if (st_q.cand_v && st_q.cand == hit) begin
                    st_d.locked = 1'b1;
                    st_d.code   = hit;
                end
            end else if (near) begin
                st_d.cand_v = 1'b0;
            end else begin
                st_d.cand_v = 1'b0;
                st_d.locked = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked    = st_q.locked;
    assign rate_code = st_q.code;

    // R4: lock only ever rises on an exact legal measurement
    a_r4_lock_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(meas_valid && exact));
    // R5: near-miss count keeps lock and code
    a_r5_near_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && near && !exact && locked) |=> (locked && $stable(rate_code)));
    // R6: far count drops lock
    a_r6_far_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && !near) |=> !locked);
endmodule

// File: rtl/mar_tick_gen.sv
module mar_tick_gen #(
    parameter int TICKS = 32,
    parameter int DIV_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                locked,
    input  mar_pkg::rate_code_t rate_code,
    output logic                tick
);
    import mar_pkg::*;

    localparam int IDX_W = $clog2(TICKS + 1);
    localparam logic [IDX_W-1:0] IDX_DONE = IDX_W'(TICKS);

    typedef struct packed {
        logic             tick;
        logic [DIV_W-1:0] ph;
        logic [IDX_W-1:0] idx;
    } tg_state_t;

    tg_state_t        st_d, st_q;
    logic [DIV_W-1:0] div_m1;

    assign div_m1 = DIV_W'(rate_div(int'(rate_code)) - 1);

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!locked) begin
            st_d.ph  = '0;
            st_d.idx = IDX_DONE;
        end else if (frame_start) begin
            st_d.tick = 1'b1;
            st_d.ph   = '0;
            st_d.idx  = IDX_W'(1);
        end else if (st_q.idx < IDX_DONE) begin
            if (st_q.ph >= div_m1) begin
                st_d.tick = 1'b1;
                st_d.ph   = '0;
                st_d.idx  = st_q.idx + 1'b1;
            end else begin
                st_d.ph = st_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{tick: 1'b0, ph: '0, idx: IDX_DONE};
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    // R7: strobe follows a frame sync edge seen while locked
    a_r7_frame_anchor: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && locked) |=> tick);
    // R7: with a divide above one, strobes never come back to back inside a frame
    a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_m1 != '0 && !frame_start) |=> !tick);
    // R7: never more strobes than the per-frame budget
    a_r7_budget: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= IDX_DONE);
    // R8: no strobe while unlocked
    a_r8_idle_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> !tick);
endmodule

// File: rtl/mclk_autorange.sv
module mclk_autorange #(
    parameter int CNT_W = 10,
    parameter int DIV_W = 5,
    parameter int TICKS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fsync,
    output logic [2:0] rate_code,
    output logic       locked,
    output logic       seq_tick
);
    logic                frame_start;
    logic                meas_valid;
    logic [CNT_W-1:0]    meas_cnt;
    mar_pkg::rate_code_t code_w;
    logic                lock_w;

    mar_frame_meter #(.CNT_W(CNT_W)) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .frame_start (frame_start),
        .meas_valid  (meas_valid),
        .meas_cnt    (meas_cnt)
    );

    mar_ratio_lock #(.CNT_W(CNT_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .meas_cnt   (meas_cnt),
        .locked     (lock_w),
        .rate_code  (code_w)
    );

    mar_tick_gen #(.TICKS(TICKS), .DIV_W(DIV_W)) u_ticks (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .locked      (lock_w),
        .rate_code   (code_w),
        .tick        (seq_tick)
    );

    assign rate_code = code_w;
    assign locked    = lock_w;
endmodule

// File: tb/sim_mclk_autorange.sv
`timescale 1ns/1ps
module sim_mclk_autorange;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic [2:0] rate_code;
    logic       locked;
    logic       seq_tick;

    int checks = 0;
    int errors = 0;

    // captured by drive_frame
    int lk0, lk1, rc1, f_ticks, f_bad, f_badc;

    always #2 clk = ~clk;

    mclk_autorange u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .rate_code (rate_code),
        .locked    (locked),
        .seq_tick  (seq_tick)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // divexp: -1 skip pattern, 0 expect no strobe, >0 expect strobes every divexp
    task automatic drive_frame(input int p, input int hi, input int divexp);
        f_ticks = 0; f_bad = 0; f_badc = -1;
        for (int c = 0; c < p; c++) begin
            bit exp_t;
            @(negedge clk);
            fsync = (c < hi);
            @(posedge clk);
            #1;
            if (c == 0) lk0 = int'(locked);
            if (c == 1) begin lk1 = int'(locked); rc1 = int'(rate_code); end
            exp_t = (divexp > 0) && (c % divexp == 0) && (c / divexp < 32);
            if (seq_tick) f_ticks++;
            if (divexp >= 0 && seq_tick != exp_t && f_bad == 0) begin
                f_bad = 1; f_badc = c;
            end
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(locked == 1'b0,   "R1", "locked in reset", int'(locked), 0);
        chk(seq_tick == 1'b0, "R1", "tick in reset", int'(seq_tick), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(rate_code == 3'd0, "R1", "code after reset", int'(rate_code), 0);
        chk(locked == 1'b0,    "R1", "locked after reset", int'(locked), 0);
    endtask

    task automatic t_lock64();
        drive_frame(64, 8, 0);
        chk(f_bad == 0, "R8", "no strobe first frame", f_badc, -1);
        drive_frame(64, 8, 0);
        drive_frame(64, 8, 0);
        chk(lk0 == 0, "R2", "no lock before third edge settles", lk0, 0);
        chk(lk1 == 1, "R4", "lock timing", lk1, 1);
        chk(rc1 == 1, "R3", "code for 64", rc1, 1);
        chk(f_ticks == 0, "R8", "no strobe in lock frame", f_ticks, 0);
        drive_frame(64, 8, 2);
        chk(f_bad == 0,    "R7", "pattern D=2 first bad cycle", f_badc, -1);
        chk(f_ticks == 32, "R7", "strobe count 64", f_ticks, 32);
        drive_frame(64, 1, 2);
        chk(f_bad == 0 && f_ticks == 32, "R9", "short sync pattern", f_badc, -1);
        drive_frame(64, 40, 2);
        chk(f_bad == 0 && f_ticks == 32, "R9", "long sync pattern", f_badc, -1);
    endtask

    task automatic t_frac193();
        drive_frame(193, 8, -1);
        drive_frame(193, 8, -1);
        drive_frame(193, 8, -1);
        chk(rc1 == 3 && lk1 == 1, "R3", "code for 193", rc1, 3);
        drive_frame(193, 8, 6);
        chk(f_bad == 0,    "R7", "193 pattern (last gap 7)", f_badc, -1);
        chk(f_ticks == 32, "R7", "strobe count 193", f_ticks, 32);
    endtask

    task automatic t_sweep();
        int rates [5] = '{32, 192, 256, 320, 512};
        int codes [5] = '{0, 2, 4, 5, 6};
        int divs  [5] = '{1, 6, 8, 10, 16};
        for (int i = 0; i < 5; i++) begin
            drive_frame(rates[i], 8, -1);
            drive_frame(rates[i], 8, -1);
            drive_frame(rates[i], 8, -1);
            chk(rc1 == codes[i], "R3", $sformatf("code for %0d", rates[i]), rc1, codes[i]);
            chk(lk1 == 1, "R4", $sformatf("relock to %0d", rates[i]), lk1, 1);
            drive_frame(rates[i], 8, divs[i]);
            chk(f_bad == 0 && f_ticks == 32, "R7",
                $sformatf("pattern at %0d first bad cycle", rates[i]), f_badc, -1);
        end
    endtask

    task automatic t_near();
        // locked at 512 (code 6) on entry
        drive_frame(320, 8, -1);
        drive_frame(321, 8, -1);
        chk(rc1 == 6 && lk1 == 1, "R5", "exact 320 alone no relock", rc1, 6);
        drive_frame(320, 8, -1);
        chk(rc1 == 6 && lk1 == 1, "R5", "near 321 keeps lock", rc1, 6);
        drive_frame(320, 8, 16);
        chk(rc1 == 6, "R5", "near breaks run of two", rc1, 6);
        chk(f_bad == 0, "R5", "strobe pattern kept at D=16", f_badc, -1);
        drive_frame(320, 8, -1);
        chk(rc1 == 5 && lk1 == 1, "R4", "relock to 320", rc1, 5);
    endtask

    task automatic t_far();
        drive_frame(100, 8, -1);
        drive_frame(320, 8, -1);
        chk(lk1 == 0, "R6", "far count drops lock", lk1, 0);
        drive_frame(320, 8, 0);
        chk(f_ticks == 0, "R8", "no strobe while unlocked", f_ticks, 0);
        drive_frame(320, 8, -1);
        chk(lk1 == 1 && rc1 == 5, "R4", "relock after loss", rc1, 5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_lock64();
        t_frac193();
        t_sweep();
        t_near();
        t_far();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule